// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a two-part logical address, made of a segment number and a byte offset inside that segment, onto a flat physical address. The segment table lives in ordinary memory. Two configuration inputs describe it: one gives the physical address where the table starts, and the other gives how many entries it holds. For each request the block fetches one table entry through a simple read port. It then applies a fixed sequence of legality checks. The response carries either the base of the segment plus the offset, or a fault flag with a cause code that names the first check that failed.

The block handles one request at a time. A request is accepted with a valid/ready handshake. A response is offered with its own valid/ready pair and is held until it is taken. The table read port has one request strobe and one address. Read data returns on a later cycle, marked by a data-valid strobe, and the latency may vary. The block never writes the table. Filling and maintaining the table is left to other logic.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_rd_en` are 0. `req_ready` is 1 only while no request is in progress, so a new request is accepted only after the previous response has been taken.
- R2: A segment number that is not strictly less than `cfg_tbl_len` gives cause code 1 (segment out of range), and no table read is issued for that request.
- R3: A legal segment number causes exactly one single-cycle `mem_rd_en` pulse, at address `cfg_tbl_base + seg * ENT_STRIDE`, taken modulo 2^PA_W.
- R4: An entry whose valid bit is 0 gives cause code 2 (invalid entry).
- R5: An offset that is greater than or equal to the entry's limit gives cause code 3 (offset out of bounds). A limit of 0 therefore rejects every offset.
- R6: Access code 0 (read) needs the read bit, 1 (write) needs the write bit and 2 (execute) needs the execute bit. Code 3 is always refused. A refused access gives cause code 4 (permission denied).
- R7: When several checks fail, the reported cause is the lowest-numbered one: segment range first, then valid bit, then bounds, then permission.
- R8: When every check passes, `rsp_fault` is 0, `rsp_cause` is 0 and `rsp_paddr` is the entry base plus the zero-extended offset, modulo 2^PA_W.
- R9: When `rsp_fault` is 1, `rsp_paddr` is 0. While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay unchanged.
- R10: A table word is laid out from the least significant bit upward as follows: base (PA_W bits), limit (OFF_W+1 bits), execute bit, write bit, read bit, valid bit (the most significant bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| cfg_tbl_base | input | PA_W | Physical address of table entry 0 |
| cfg_tbl_len | input | SEG_W+1 | Number of table entries |
| mem_rd_en | output | 1 | Table read strobe, one cycle long |
| mem_rd_addr | output | PA_W | Table read address |
| mem_rd_valid | input | 1 | Table read data is present |
| mem_rd_data | input | PA_W+OFF_W+5 | Table entry word |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 1 | Translation refused |
| rsp_cause | output | 3 | 0 none, 1 segment range, 2 invalid, 3 bounds, 4 permission |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |

## Verification
The assertions assume three things about the inputs. First, `cfg_tbl_base` and `cfg_tbl_len` do not change while a request is in progress. Second, the memory returns exactly one `mem_rd_valid` pulse for each read strobe. Third, that pulse comes no earlier than the cycle after the strobe. The stimulus meets these rules by changing the configuration only while the block is idle. Its memory model answers each strobe once, after a random delay of one to three cycles. Random table contents, offsets placed near each limit, and response back-pressure are mixed with directed cases: a table length of zero, the last legal segment, an offset exactly at the limit, and entries that fail several checks at once.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_SEG_RANGE = 3'd1,
    CAUSE_INVALID   = 3'd2,
    CAUSE_BOUNDS    = 3'd3,
    CAUSE_PERM      = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;

endpackage

// File: rtl/seg_xlate_addr_gen.sv
module seg_xlate_addr_gen #(
  parameter int SEG_W      = 4,
  parameter int PA_W       = 24,
  parameter int ENT_STRIDE = 4
) (
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [SEG_W-1:0] seg,
  output logic [PA_W-1:0]  fetch_addr
);

  localparam bit IS_POW2 = (ENT_STRIDE > 0) && ((ENT_STRIDE & (ENT_STRIDE - 1)) == 0);
  localparam int SHIFT   = (ENT_STRIDE > 1) ? $clog2(ENT_STRIDE) : 0;

  logic [PA_W-1:0] seg_ext;
  logic [PA_W-1:0] scaled;

  assign seg_ext = PA_W'(seg);

  generate
    if (IS_POW2) begin : g_shift
      assign scaled = seg_ext << SHIFT;
    end else begin : g_mult
      assign scaled = seg_ext * PA_W'(ENT_STRIDE);
    end
  endgenerate

  assign fetch_addr = tbl_base + scaled;

endmodule

// File: rtl/seg_xlate_entry_check.sv
module seg_xlate_entry_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 24,
  localparam int LIM_W = OFF_W + 1,
  localparam int ENT_W = PA_W + LIM_W + 4
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       acc,
  output cause_e           cause,
  output logic [PA_W-1:0]  paddr
);

  localparam int LIM_LSB = PA_W;
  localparam int X_BIT   = PA_W + LIM_W;
  localparam int W_BIT   = X_BIT + 1;
  localparam int R_BIT   = X_BIT + 2;
  localparam int V_BIT   = X_BIT + 3;

  logic [PA_W-1:0]  seg_base;
  logic [LIM_W-1:0] seg_limit;
  logic             ok_valid;
  logic             ok_bounds;
  logic             ok_perm;

  assign seg_base  = entry[PA_W-1:0];
  assign seg_limit = entry[LIM_LSB +: LIM_W];
  assign ok_valid  = entry[V_BIT];
  assign ok_bounds = ({1'b0, off} < seg_limit);

  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  ok_perm = entry[R_BIT];
      ACC_WRITE: ok_perm = entry[W_BIT];
      ACC_EXEC:  ok_perm = entry[X_BIT];
      default:   ok_perm = 1'b0;
    endcase
  end

  always_comb begin
    if (!ok_valid) begin
      cause = CAUSE_INVALID;
    end else if (!ok_bounds) begin
      cause = CAUSE_BOUNDS;
    end else if (!ok_perm) begin
      cause = CAUSE_PERM;
    end else begin
      cause = CAUSE_NONE;
    end
  end

  assign paddr = seg_base + PA_W'(off);

endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  input  logic [SEG_W:0]   cfg_tbl_len,
  output logic             rd_strobe,
  input  logic             rd_done,
  input  cause_e           chk_cause,
  input  logic [PA_W-1:0]  chk_paddr,
  output logic [SEG_W-1:0] seg_q,
  output logic [OFF_W-1:0] off_q,
  output logic [1:0]       acc_q,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output cause_e           cause_q,
  output logic [PA_W-1:0]  paddr_q
);

  state_e          state_q, state_d;
  logic            accept;
  logic            seg_legal;
  logic            cap_en;
  logic            res_en;
  cause_e          cause_d;
  logic [PA_W-1:0] paddr_d;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign seg_legal = ({1'b0, req_seg} < cfg_tbl_len);
  assign cap_en    = accept;

  always_comb begin
    state_d = state_q;
    res_en  = 1'b0;
    cause_d = cause_q;
    paddr_d = paddr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (seg_legal) begin
            state_d = ST_ISSUE;
          end else begin
            state_d = ST_RESP;
            res_en  = 1'b1;
            cause_d = CAUSE_SEG_RANGE;
            paddr_d = '0;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_done) begin
          state_d = ST_RESP;
          res_en  = 1'b1;
          cause_d = chk_cause;
          paddr_d = (chk_cause == CAUSE_NONE) ? chk_paddr : '0;
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      off_q <= '0;
      acc_q <= '0;
    end else if (cap_en) begin
      seg_q <= req_seg;
      off_q <= req_off;
      acc_q <= req_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_NONE;
      paddr_q <= '0;
    end else if (res_en) begin
      cause_q <= cause_d;
      paddr_q <= paddr_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rd_strobe = (state_q == ST_ISSUE);
  assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W      = 4,
  parameter int OFF_W      = 12,
  parameter int PA_W       = 24,
  parameter int ENT_STRIDE = 4,
  localparam int ENT_W     = PA_W + OFF_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  input  logic [PA_W-1:0]  cfg_tbl_base,
  input  logic [SEG_W:0]   cfg_tbl_len,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [ENT_W-1:0] mem_rd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [2:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);

  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;
  cause_e           chk_cause;
  logic [PA_W-1:0]  chk_paddr;
  cause_e           cause_q;
  logic [PA_W-1:0]  paddr_q;

  seg_xlate_ctrl #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_seg     (req_seg),
    .req_off     (req_off),
    .req_acc     (req_acc),
    .cfg_tbl_len (cfg_tbl_len),
    .rd_strobe   (mem_rd_en),
    .rd_done     (mem_rd_valid),
    .chk_cause   (chk_cause),
    .chk_paddr   (chk_paddr),
    .seg_q       (seg_q),
    .off_q       (off_q),
    .acc_q       (acc_q),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .cause_q     (cause_q),
    .paddr_q     (paddr_q)
  );

  seg_xlate_addr_gen #(
    .SEG_W      (SEG_W),
    .PA_W       (PA_W),
    .ENT_STRIDE (ENT_STRIDE)
  ) addr_i (
    .tbl_base   (cfg_tbl_base),
    .seg        (seg_q),
    .fetch_addr (mem_rd_addr)
  );

  seg_xlate_entry_check #(
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
  ) check_i (
    .entry (mem_rd_data),
    .off   (off_q),
    .acc   (acc_q),
    .cause (chk_cause),
    .paddr (chk_paddr)
  );

  assign rsp_cause = cause_q;
  assign rsp_fault = (cause_q != CAUSE_NONE);
  assign rsp_paddr = paddr_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 4,
  parameter int PA_W  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic [SEG_W:0]   cfg_tbl_len,
  input logic             mem_rd_en,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [2:0]       rsp_cause,
  input logic [PA_W-1:0]  rsp_paddr
);

  logic [SEG_W-1:0] cap_seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_seg <= '0;
    end else if (req_valid && req_ready) begin
      cap_seg <= req_seg;
    end
  end

  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R1

  AST_NO_READ_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ({1'b0, cap_seg} < cfg_tbl_len)); // R2

  AST_READ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R3

  AST_CAUSE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cause <= 3'd4)); // R7

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R9

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cause) && $stable(rsp_paddr))); // R9

endmodule

bind seg_xlate_top seg_xlate_chk #(
  .SEG_W (SEG_W),
  .PA_W  (PA_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_seg     (req_seg),
  .cfg_tbl_len (cfg_tbl_len),
  .mem_rd_en   (mem_rd_en),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_fault   (rsp_fault),
  .rsp_cause   (rsp_cause),
  .rsp_paddr   (rsp_paddr)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;

  localparam int SEG_W  = 4;
  localparam int OFF_W  = 12;
  localparam int PA_W   = 24;
  localparam int STRIDE = 4;
  localparam int LIM_W  = OFF_W + 1;
  localparam int ENT_W  = PA_W + OFF_W + 5;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [SEG_W-1:0] req_seg;
  logic [OFF_W-1:0] req_off;
  logic [1:0]       req_acc;
  logic [PA_W-1:0]  cfg_tbl_base;
  logic [SEG_W:0]   cfg_tbl_len;
  logic             mem_rd_en;
  logic [PA_W-1:0]  mem_rd_addr;
  logic             mem_rd_valid;
  logic [ENT_W-1:0] mem_rd_data;
  logic             rsp_valid;
  logic             rsp_ready;
  logic             rsp_fault;
  logic [2:0]       rsp_cause;
  logic [PA_W-1:0]  rsp_paddr;

  int n_checks = 0;
  int n_errors = 0;

  logic [ENT_W-1:0] tbl_mem [0:255];
  int               rd_count = 0;
  logic [PA_W-1:0]  last_rd_addr;
  bit               pend = 0;
  int               lat_cnt = 0;
  logic [7:0]       pend_idx;

  seg_xlate_top #(
    .SEG_W (SEG_W), .OFF_W (OFF_W), .PA_W (PA_W), .ENT_STRIDE (STRIDE)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_seg (req_seg), .req_off (req_off), .req_acc (req_acc),
    .cfg_tbl_base (cfg_tbl_base), .cfg_tbl_len (cfg_tbl_len),
    .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
    .rsp_fault (rsp_fault), .rsp_cause (rsp_cause), .rsp_paddr (rsp_paddr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Table memory model: answers each strobe once, 1..3 cycles later
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_valid = 1'b0;
      pend = 0;
    end else begin
      mem_rd_valid = 1'b0;
      if (pend) begin
        if (lat_cnt == 0) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = tbl_mem[pend_idx];
          pend = 0;
        end else begin
          lat_cnt = lat_cnt - 1;
        end
      end
      if (mem_rd_en) begin
        rd_count++;
        last_rd_addr = mem_rd_addr;
        pend_idx = mem_rd_addr[7:0];
        lat_cnt = int'($urandom % 3);
        pend = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ENT_W-1:0] mk_entry(bit v, bit r, bit w, bit x,
                                                logic [LIM_W-1:0] lim, logic [PA_W-1:0] base);
    return {v, r, w, x, lim, base};
  endfunction

  function automatic int exp_cause(logic [SEG_W-1:0] seg, logic [OFF_W-1:0] off,
                                   logic [1:0] acc, logic [ENT_W-1:0] e);
    bit perm;
    if ({1'b0, seg} >= cfg_tbl_len) return 1;
    if (!e[ENT_W-1]) return 2;
    if ({1'b0, off} >= e[PA_W +: LIM_W]) return 3;
    case (acc)
      2'd0: perm = e[ENT_W-2];
      2'd1: perm = e[ENT_W-3];
      2'd2: perm = e[ENT_W-4];
      default: perm = 1'b0;
    endcase
    if (!perm) return 4;
    return 0;
  endfunction

  function automatic string cause_req(int c);
    case (c)
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic do_txn(input logic [SEG_W-1:0] seg, input logic [OFF_W-1:0] off,
                        input logic [1:0] acc, input string tag);
    int               reads0;
    int               ec;
    logic [PA_W-1:0]  exp_addr;
    logic [PA_W-1:0]  exp_pa;
    logic [ENT_W-1:0] ent;
    int               wait_n;
    logic [2:0]       c0;
    logic [PA_W-1:0]  p0;
    bit               stable_ok;
    string            rq;
    exp_addr = cfg_tbl_base + PA_W'(seg) * PA_W'(STRIDE);
    ent = tbl_mem[exp_addr[7:0]];
    ec = exp_cause(seg, off, acc, ent);
    exp_pa = (ec == 0) ? ent[PA_W-1:0] + PA_W'(off) : '0;
    rq = (tag != "") ? tag : cause_req(ec);
    reads0 = rd_count;
    @(negedge clk);
    req_valid = 1'b1; req_seg = seg; req_off = off; req_acc = acc;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_n = 0;
    while (!rsp_valid && wait_n < 40) begin
      @(negedge clk);
      wait_n++;
    end
    c0 = rsp_cause; p0 = rsp_paddr; stable_ok = 1;
    repeat (int'($urandom % 3)) begin
      @(negedge clk);
      if (!rsp_valid || rsp_cause != c0 || rsp_paddr != p0) stable_ok = 0;
    end
    check(stable_ok, "R9", "response held under back-pressure", rsp_paddr, p0);
    check(rsp_valid && rsp_cause == 3'(ec), rq, "cause", rsp_cause, ec);
    check(rsp_fault == (ec != 0), rq, "fault flag", rsp_fault, ec != 0);
    check(rsp_paddr == exp_pa, (ec == 0) ? "R8" : "R9", "paddr", rsp_paddr, exp_pa);
    if (ec == 1) begin
      check(rd_count == reads0, "R2", "table reads", rd_count - reads0, 0);
    end else begin
      check(rd_count == reads0 + 1, "R3", "table reads", rd_count - reads0, 1);
      check(last_rd_addr == exp_addr, "R3", "read address", last_rd_addr, exp_addr);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R1", "idle after response", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic fill_random();
    for (int i = 0; i < 256; i++) begin
      tbl_mem[i] = mk_entry(($urandom % 8) != 0, $urandom % 2 == 0 ? 1'b1 : ($urandom % 2 == 1),
                            $urandom % 2 == 1, $urandom % 2 == 1,
                            LIM_W'($urandom % 4097), PA_W'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0; req_acc = '0;
    rsp_ready = 1'b0; cfg_tbl_base = 24'h000010; cfg_tbl_len = 5'd8;
    mem_rd_valid = 1'b0; mem_rd_data = '0;
    for (int i = 0; i < 256; i++) tbl_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en, "R1", "reset state",
          {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en, "R1", "after reset release",
          {req_ready, rsp_valid, mem_rd_en}, 3'b100);

    // Directed corner cases; base 0x10, stride 4 -> entry s at 0x10 + 4*s
    tbl_mem[8'h10] = mk_entry(1, 1, 0, 0, 13'd100, 24'h00A000);
    do_txn(4'd0, 12'd99, 2'd0, "R8");      // last legal offset
    do_txn(4'd0, 12'd100, 2'd0, "R5");     // offset at limit
    do_txn(4'd0, 12'd5, 2'd1, "R6");       // write refused
    do_txn(4'd0, 12'd5, 2'd3, "R6");       // reserved code refused
    tbl_mem[8'h2C] = mk_entry(1, 1, 1, 1, 13'd4096, 24'hFFFFF0);
    do_txn(4'd7, 12'hFFF, 2'd2, "R8");     // last legal segment, address wraps
    do_txn(4'd8, 12'd0, 2'd0, "R2");       // segment equal to length
    tbl_mem[8'h14] = mk_entry(0, 0, 0, 0, 13'd0, 24'h123456);
    do_txn(4'd1, 12'd50, 2'd3, "R7");      // invalid wins over bounds and perm
    tbl_mem[8'h18] = mk_entry(1, 0, 0, 0, 13'd10, 24'h000100);
    do_txn(4'd2, 12'd20, 2'd0, "R7");      // bounds wins over perm
    tbl_mem[8'h1C] = mk_entry(1, 1, 1, 1, 13'd0, 24'h000200);
    do_txn(4'd3, 12'd0, 2'd0, "R5");       // zero limit
    tbl_mem[8'h20] = mk_entry(1, 0, 0, 1, 13'd16, 24'h000300);
    do_txn(4'd4, 12'd15, 2'd2, "R10");     // exec bit position
    do_txn(4'd4, 12'd15, 2'd0, "R10");     // read bit clear
    cfg_tbl_len = 5'd0;
    do_txn(4'd0, 12'd0, 2'd0, "R2");       // empty table
    cfg_tbl_len = 5'd16;
    do_txn(4'd15, 12'd0, 2'd0, "");        // full table, top segment

    // Constrained random
    for (int t = 0; t < 400; t++) begin
      logic [SEG_W-1:0] s;
      logic [OFF_W-1:0] o;
      logic [PA_W-1:0]  ea;
      if (t % 40 == 0) fill_random();
      cfg_tbl_base = PA_W'($urandom % 64);
      cfg_tbl_len  = 5'($urandom % 17);
      s = SEG_W'($urandom);
      ea = cfg_tbl_base + PA_W'(s) * PA_W'(STRIDE);
      if ($urandom % 2 == 0) begin
        o = OFF_W'(int'(tbl_mem[ea[7:0]][PA_W +: LIM_W]) - 1 + int'($urandom % 3));
      end else begin
        o = OFF_W'($urandom);
      end
      do_txn(s, o, 2'($urandom), "");
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule